// File: doc/BRIEF.md
# Strobed Synchronous PCM Serial Port

This block carries one 8-bit companded voice sample in each direction per 8 kHz frame. It runs on a strobed serial link whose bit clock, at 512 kHz or faster, also clocks the block. The strobe is active high and marks a single 8-bit slot that transmit and receive share. Inside that slot, outgoing bits change on rising clock edges and incoming bits are taken on falling edges. A byte received in a frame is handed to the receive path in that same frame.

The transmit side keeps the last sample offered through a valid strobe and sends it in every slot. The companding-law select picks which negative-zero "quiet" code the mute inputs force. With law_a_i high that code is 0x55 (A-law); with it low the code is 0x7F (µ-law). The serial output comes with an enable, and the pad cell uses that enable to float the line outside the slot.

Top module: `pcm_strobe_port`

## Requirements
- R1: While rst_ni is low, rx_valid_o is 0, rx_sample_o is 0x00 and sdo_oe_o is 0.
- R2: Out of reset, sdo_oe_o is high exactly while stb_i is high.
- R3: The transmit byte is sent MSB first. Its first bit is on sdo_o as soon as the strobe rises, and each later bit replaces the previous one at a rising edge of clk_i while stb_i stays high.
- R4: sdi_i is sampled MSB first on the falling edges inside the slot. At the rising edge that follows the eighth sample, rx_sample_o takes the byte and rx_valid_o pulses high for exactly one cycle, in the same frame.
- R5: tx_valid_i high at a rising edge stores tx_sample_i. The byte for a slot is loaded at every rising edge that sees stb_i low, so a sample stored during a slot leaves that slot's bits unchanged and goes out in the next slot.
- R6: Until a first sample has been stored after reset, every slot carries the quiet code of the selected law.
- R7: With tx_mute_i high at the load edge, the slot carries the quiet code: 0x7F when law_a_i=0, 0x55 when law_a_i=1.
- R8: With rx_mute_i high at the delivery edge, rx_sample_o takes the quiet code of law_a_i instead of the received byte, and rx_valid_o still pulses.
- R9: A strobe that lasts fewer than eight clocks produces no rx_valid_o pulse and leaves rx_sample_o unchanged. The next slot again starts from the MSB of a freshly loaded byte.
- R10: A stored sample is sent again in every slot until a new one replaces it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock, which also clocks the block |
| rst_ni | input | 1 | Asynchronous reset, active low |
| stb_i | input | 1 | Slot strobe, active high |
| sdi_i | input | 1 | Serial receive data |
| law_a_i | input | 1 | 1 selects A-law quiet code, 0 selects µ-law |
| rx_mute_i | input | 1 | Replace delivered receive byte with quiet code |
| tx_mute_i | input | 1 | Replace transmitted byte with quiet code |
| tx_sample_i | input | 8 | Sample to transmit |
| tx_valid_i | input | 1 | Stores tx_sample_i |
| sdo_o | output | 1 | Serial transmit data |
| sdo_oe_o | output | 1 | Drive enable for sdo_o |
| rx_sample_o | output | 8 | Received byte |
| rx_valid_o | output | 1 | One-cycle pulse on a new rx_sample_o |

## Verification
The bench targets several corner cases. A short strobe is one: a design that does not clear its partial state would deliver a stale or misaligned byte, or resume transmit mid-byte. A sample offered in the middle of a slot is another; a design that loads the shifter from it directly would corrupt the bits already in flight. The bench also sends slots before any sample exists and mutes under both laws. A wrong quiet constant, or mute sampled at the wrong edge, shows up there as the wrong byte on the line or at the receive output. The valid pulse is timed to the cycle, so a frame delay or a doubled pulse is caught.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;
  localparam int unsigned SAMPLE_W = 8;
  localparam logic [SAMPLE_W-1:0] MU_QUIET = 8'h7F;
  localparam logic [SAMPLE_W-1:0] A_QUIET  = 8'h55;

  function automatic logic [SAMPLE_W-1:0] quiet_code(input logic law_a);
    return law_a ? A_QUIET : MU_QUIET;
  endfunction
endpackage

// File: rtl/pcm_tx_shifter.sv
module pcm_tx_shifter
  import pcm_port_pkg::*;
#(
  parameter int unsigned W = SAMPLE_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         stb_i,
  input  logic         law_a_i,
  input  logic         tx_mute_i,
  input  logic [W-1:0] tx_sample_i,
  input  logic         tx_valid_i,
  output logic         sdo_o,
  output logic         sdo_oe_o
);
  logic [W-1:0] hold_q, shreg_q, load_byte;
  logic         hold_vld_q;

  always_comb begin
    if (tx_mute_i || !hold_vld_q) load_byte = W'(quiet_code(law_a_i));
    else                          load_byte = hold_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q     <= '0;
      hold_vld_q <= 1'b0;
    end else if (tx_valid_i) begin
      hold_q     <= tx_sample_i;
      hold_vld_q <= 1'b1;
    end
  end

  // idle edges reload, slot edges shift
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     shreg_q <= '0;
    else if (!stb_i) shreg_q <= load_byte;
    else             shreg_q <= {shreg_q[W-2:0], 1'b0};
  end

  assign sdo_o    = shreg_q[W-1];
  assign sdo_oe_o = stb_i & rst_ni;
endmodule

// File: rtl/pcm_rx_shifter.sv
module pcm_rx_shifter
  import pcm_port_pkg::*;
#(
  parameter int unsigned W = SAMPLE_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         stb_i,
  input  logic         sdi_i,
  input  logic         law_a_i,
  input  logic         rx_mute_i,
  output logic [W-1:0] rx_sample_o,
  output logic         rx_valid_o
);
  localparam int unsigned CNT_W = $clog2(W + 1);

  logic [W-1:0]     shreg_q;
  logic [CNT_W-1:0] cnt_q;
  logic             done_q;

  // falling-edge capture domain
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg_q <= '0;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else if (!stb_i) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= (cnt_q == CNT_W'(W - 1));
      if (cnt_q != CNT_W'(W)) begin
        shreg_q <= {shreg_q[W-2:0], sdi_i};
        cnt_q   <= cnt_q + 1'b1;
      end
    end
  end

  // delivery at the rising edge after the last sample
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_sample_o <= '0;
      rx_valid_o  <= 1'b0;
    end else begin
      rx_valid_o <= done_q;
      if (done_q) rx_sample_o <= rx_mute_i ? W'(quiet_code(law_a_i)) : shreg_q;
    end
  end

  AST_RX_PULSE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o); // R4
  AST_RX_IN_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> $past(stb_i)); // R4
  AST_RX_MUTE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_o && $past(rx_mute_i)) |-> (rx_sample_o == W'(quiet_code($past(law_a_i))))); // R8
endmodule

// File: rtl/pcm_strobe_port.sv
module pcm_strobe_port
  import pcm_port_pkg::*;
#(
  parameter int unsigned W = SAMPLE_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         stb_i,
  input  logic         sdi_i,
  input  logic         law_a_i,
  input  logic         rx_mute_i,
  input  logic         tx_mute_i,
  input  logic [W-1:0] tx_sample_i,
  input  logic         tx_valid_i,
  output logic         sdo_o,
  output logic         sdo_oe_o,
  output logic [W-1:0] rx_sample_o,
  output logic         rx_valid_o
);
  pcm_tx_shifter #(.W(W)) u_tx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .stb_i       (stb_i),
    .law_a_i     (law_a_i),
    .tx_mute_i   (tx_mute_i),
    .tx_sample_i (tx_sample_i),
    .tx_valid_i  (tx_valid_i),
    .sdo_o       (sdo_o),
    .sdo_oe_o    (sdo_oe_o)
  );

  pcm_rx_shifter #(.W(W)) u_rx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .stb_i       (stb_i),
    .sdi_i       (sdi_i),
    .law_a_i     (law_a_i),
    .rx_mute_i   (rx_mute_i),
    .rx_sample_o (rx_sample_o),
    .rx_valid_o  (rx_valid_o)
  );

  // both quiet codes have a zero MSB
  AST_TX_MUTE_MSB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(stb_i) && $past(tx_mute_i)) |-> !sdo_o); // R7
endmodule

// File: tb/sim_pcm_strobe_port.sv
module sim_pcm_strobe_port;
  localparam int CLK_PERIOD = 20;
  localparam int Q = CLK_PERIOD / 4;
  localparam int H = CLK_PERIOD / 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       stb = 1'b0, sdi = 1'b0, law_a = 1'b0, rxm = 1'b0, txm = 1'b0, txv = 1'b0;
  logic [7:0] txs = 8'h00;
  logic       sdo, sdo_oe, rx_valid;
  logic [7:0] rx_sample;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  // behavioural reference state
  logic [7:0] m_hold = 8'h00;
  bit         m_hold_vld = 0;
  logic [7:0] m_rx_last = 8'h00;

  always #(CLK_PERIOD/2) clk = ~clk;

  pcm_strobe_port u0 (
    .clk_i(clk), .rst_ni(rst_n), .stb_i(stb), .sdi_i(sdi), .law_a_i(law_a),
    .rx_mute_i(rxm), .tx_mute_i(txm), .tx_sample_i(txs), .tx_valid_i(txv),
    .sdo_o(sdo), .sdo_oe_o(sdo_oe), .rx_sample_o(rx_sample), .rx_valid_o(rx_valid)
  );

  function automatic logic [7:0] quiet(input logic a);
    return a ? 8'h55 : 8'h7F;
  endfunction

  function automatic logic [7:0] model_tx();
    return (txm || !m_hold_vld) ? quiet(law_a) : m_hold;
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #Q stb = 1'b0; txv = 1'b0;
      #H;
      chk("R2", "oe idle", sdo_oe, 0);
      chk("R4", "valid idle", rx_valid, 0);
    end
  endtask

  task automatic push_sample(input logic [7:0] b);
    @(posedge clk); #Q txs = b; txv = 1'b1; stb = 1'b0;
    m_hold = b; m_hold_vld = 1;
    @(posedge clk); #Q txv = 1'b0;
  endtask

  // len strobe clocks; inj_at >= 0 offers a new sample mid-slot
  task automatic slot(input int len, input logic [7:0] rxb, input string req,
                      input int inj_at, input logic [7:0] inj_val);
    logic [7:0] exp_tx, exp_rx;
    exp_tx = model_tx();
    for (int i = 0; i < len; i++) begin
      @(posedge clk); #Q stb = 1'b1; sdi = rxb[7-i];
      if (i == inj_at) begin txs = inj_val; txv = 1'b1; m_hold = inj_val; m_hold_vld = 1; end
      else txv = 1'b0;
      #H;
      chk("R2", "oe in slot", sdo_oe, 1);
      chk(req, $sformatf("sdo bit %0d", 7 - i), sdo, exp_tx[7-i]);
      chk("R4", "valid in slot", rx_valid, 0);
    end
    @(posedge clk); #Q stb = 1'b0; txv = 1'b0;
    #H;
    chk("R2", "oe after slot", sdo_oe, 0);
    if (len == 8) begin
      exp_rx = rxm ? quiet(law_a) : rxb;
      chk("R4", "valid pulse", rx_valid, 1);
      chk(rxm ? "R8" : "R4", "rx byte", rx_sample, exp_rx);
      m_rx_last = exp_rx;
    end else begin
      chk("R9", "no pulse on short slot", rx_valid, 0);
      chk("R9", "rx byte kept", rx_sample, m_rx_last);
    end
    idle(1);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    // R1 reset state
    #(Q * 3);
    chk("R1", "oe in reset", sdo_oe, 0);
    chk("R1", "valid in reset", rx_valid, 0);
    chk("R1", "rx byte in reset", rx_sample, 0);
    @(posedge clk); #Q rst_n = 1'b1;
    idle(2);

    // R6 nothing stored yet: quiet code on both laws
    slot(8, 8'h3C, "R6", -1, 8'h00);
    law_a = 1'b1; idle(1);
    slot(8, 8'hC3, "R6", -1, 8'h00);
    law_a = 1'b0;

    // R3 basic transfer, R10 resend
    push_sample(8'hA5);
    slot(8, 8'h96, "R3", -1, 8'h00);
    slot(8, 8'h01, "R10", -1, 8'h00);
    push_sample(8'h80);
    slot(8, 8'h2A, "R3", -1, 8'h00);

    // R7 / R8 mutes, both laws
    txm = 1'b1; rxm = 1'b1; idle(1);
    slot(8, 8'hF0, "R7", -1, 8'h00);
    law_a = 1'b1; idle(1);
    slot(8, 8'h0F, "R7", -1, 8'h00);
    txm = 1'b0; rxm = 1'b0; idle(1);
    slot(8, 8'hAA, "R10", -1, 8'h00);

    // R9 short strobe then full slot restarts from MSB
    push_sample(8'h2A);
    slot(5, 8'hFF, "R9", -1, 8'h00);
    slot(8, 8'h5A, "R9", -1, 8'h00);
    slot(1, 8'h80, "R9", -1, 8'h00);
    slot(8, 8'h00, "R9", -1, 8'h00);

    // R5 sample offered mid-slot leaves current bits untouched
    law_a = 1'b0; push_sample(8'h0F);
    slot(8, 8'h81, "R5", 3, 8'hF3);
    slot(8, 8'h7E, "R5", -1, 8'h00);

    idle(2);
    report();
  end
endmodule